// File: doc/BRIEF.md
# Pipeline Stage Dependency Token Controller

This block orders the four stages of a neural-network accelerator pipeline: a loader, a matrix-multiply (GEMM) engine, a vector ALU and an output writer, chained in that order. The stages run their own instruction streams in parallel. They stay consistent with the global program order because each instruction carries four dependency flags. A flag can take a token from a neighbour before the instruction starts, or hand a token to a neighbour once it has finished. Between every two adjacent stages there are two token counters, one for each direction.

When a stage offers an instruction, the controller grants it only if the stage is idle and every token the instruction asks for is present. The tokens are consumed in the grant cycle. The controller records the instruction's hand-over flags and posts those tokens when the stage reports completion. An instruction whose only content is flags acts as a no-op that moves tokens without doing any work. The schedule uses such instructions, and hand-backs on the last GEMM of a fold, to let the loader overwrite a buffer that is too small to hold a whole tensor.

Top module: `dep_token_ctrl`

## Requirements
- R1: Each request carries a 4-bit flag field. Bit 3 takes a token from the previous stage. Bit 2 hands a token to the previous stage. Bit 1 takes a token from the next stage. Bit 0 hands a token to the next stage. Stage index 0 is the loader, 1 the GEMM engine, 2 the ALU and 3 the writer. A request with flags 0000 is granted at once by an idle stage.
- R2: A request with bit 3 set is held off (`issue` low) until the counter from the previous stage is nonzero. The grant decrements that counter by one.
- R3: A request with bit 1 set is held off until the counter from the next stage is nonzero. The grant decrements that counter by one.
- R4: Hand-over tokens (bits 2 and 0) are added when the stage pulses `done`, not when it is granted. A consumer therefore cannot start while the producer is still running.
- R5: Each stage has at most one granted instruction in flight. A new request is not granted until `done` has been seen for the previous one.
- R6: The loader ignores bits 3 and 2, and the writer ignores bits 1 and 0. A take flag pointing outside the chain never holds a request off.
- R7: Counters are 4 bits wide and saturate at 15. A hand-over into a full counter leaves it at 15 and sets `tok_err`, which stays set until reset.
- R8: If a token is taken from a counter and posted into it in the same cycle, the counter keeps its value. A take still needs a nonzero value in that cycle.
- R9: After reset every counter is zero, every stage is idle and `tok_err` is low.
- R10: A `done` pulse from an idle stage posts no tokens.
- R11: Across a full mapped convolution schedule with stage latencies varying from instruction to instruction, no take is granted before the matching hand-over has completed, and every stage runs its whole program without deadlock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_valid | input | NS (4) | Per-stage request: the stage offers its next instruction |
| req_flags | input | NS x 4 | Per-stage dependency flags of the offered instruction |
| issue | output | NS (4) | Per-stage grant, combinational in the request cycle |
| done | input | NS (4) | Per-stage completion pulse for the granted instruction |
| tok_err | output | 1 | Sticky token counter overflow flag |

## Verification
Two situations are hard to reach from the ports. The first is a counter that is taken from and posted into in the same cycle. The bench reaches it by holding a loader instruction in flight with a token already banked, then raising the loader's `done` in the same cycle as the GEMM request that takes from that counter. The second is a real interleaving of all four stages, where a stall in one stage ripples back through a buffer-limited schedule. The bench gets there by running all four stage programs concurrently, each with random latencies. A shadow account of the tokens posted and taken per counter then checks every grant.

// File: rtl/dep_tok_pkg.sv
package dep_tok_pkg;
  localparam int FLAG_W = 4;

  // Field order is the encoding seen on req_flags (MSB first).
  typedef struct packed {
    logic take_prev;
    logic give_prev;
    logic take_next;
    logic give_next;
  } dep_flags_t;
endpackage

// File: rtl/dep_flag_mask.sv
module dep_flag_mask
  import dep_tok_pkg::*;
#(
  parameter int NS  = 4,
  parameter int IDX = 0
) (
  input  dep_flags_t raw,
  output dep_flags_t eff
);
  localparam bit HAS_PREV = (IDX > 0);
  localparam bit HAS_NEXT = (IDX < NS - 1);

  generate
    if (HAS_PREV) begin : g_prev
      assign eff.take_prev = raw.take_prev;
      assign eff.give_prev = raw.give_prev;
    end else begin : g_noprev
      assign eff.take_prev = 1'b0;
      assign eff.give_prev = 1'b0;
    end
    if (HAS_NEXT) begin : g_next
      assign eff.take_next = raw.take_next;
      assign eff.give_next = raw.give_next;
    end else begin : g_nonext
      assign eff.take_next = 1'b0;
      assign eff.give_next = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/dep_token_cnt.sv
module dep_token_cnt #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  input  logic          dec,
  output logic [CW-1:0] count,
  output logic          ovf
);
  localparam logic [CW-1:0] CMAX = '1;
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_d = cnt_q;
    ovf   = 1'b0;
    unique case ({inc, dec})
      2'b10: begin
        if (cnt_q == CMAX) ovf   = 1'b1;
        else               cnt_d = cnt_q + ONE;
      end
      2'b01: begin
        if (cnt_q != '0) cnt_d = cnt_q - ONE;
      end
      default: cnt_d = cnt_q;
    endcase
  end

  assign cnt_en = inc ^ dec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count = cnt_q;
endmodule

// File: rtl/dep_stage_ctrl.sv
module dep_stage_ctrl
  import dep_tok_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  dep_flags_t flags,
  input  logic       prev_avail,
  input  logic       next_avail,
  input  logic       done,
  output logic       issue,
  output logic       take_prev,
  output logic       take_next,
  output logic       post_prev,
  output logic       post_next
);
  logic       busy_q, busy_d;
  logic [1:0] pend_q, pend_d;   // {give_prev, give_next}
  logic       finish;
  logic       state_en;

  assign issue = req_valid & ~busy_q
               & (~flags.take_prev | prev_avail)
               & (~flags.take_next | next_avail);
  assign take_prev = issue & flags.take_prev;
  assign take_next = issue & flags.take_next;

  assign finish    = done & busy_q;
  assign post_prev = finish & pend_q[1];
  assign post_next = finish & pend_q[0];

  always_comb begin
    busy_d = busy_q;
    pend_d = pend_q;
    if (issue) begin
      busy_d = 1'b1;
      pend_d = {flags.give_prev, flags.give_next};
    end else if (finish) begin
      busy_d = 1'b0;
      pend_d = 2'b00;
    end
  end

  assign state_en = issue | finish;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      pend_q <= 2'b00;
    end else if (state_en) begin
      busy_q <= busy_d;
      pend_q <= pend_d;
    end
  end
endmodule

// File: rtl/dep_token_ctrl.sv
module dep_token_ctrl
  import dep_tok_pkg::*;
#(
  parameter int NS = 4,
  parameter int CW = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NS-1:0]            req_valid,
  input  logic [NS-1:0][FLAG_W-1:0] req_flags,
  output logic [NS-1:0]            issue,
  input  logic [NS-1:0]            done,
  output logic                     tok_err
);
  localparam int NP = NS - 1;

  // Reset: asserted asynchronously, released on the clock.
  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  logic [NS-1:0]         take_prev, take_next, post_prev, post_next;
  logic [NS-1:0]         prev_avail, next_avail;
  logic [NP-1:0][CW-1:0] fwd_cnt, bwd_cnt;
  logic [NP-1:0]         fwd_ovf, bwd_ovf;
  logic                  err_q, err_d;

  genvar s, k;
  generate
    for (s = 0; s < NS; s++) begin : g_stage
      dep_flags_t f_eff;

      dep_flag_mask #(.NS(NS), .IDX(s)) u_mask (
        .raw (dep_flags_t'(req_flags[s])),
        .eff (f_eff)
      );

      if (s > 0) begin : g_pa
        assign prev_avail[s] = (fwd_cnt[s-1] != '0);
      end else begin : g_pz
        assign prev_avail[s] = 1'b0;
      end
      if (s < NS - 1) begin : g_na
        assign next_avail[s] = (bwd_cnt[s] != '0);
      end else begin : g_nz
        assign next_avail[s] = 1'b0;
      end

      dep_stage_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_sync_n),
        .req_valid  (req_valid[s]),
        .flags      (f_eff),
        .prev_avail (prev_avail[s]),
        .next_avail (next_avail[s]),
        .done       (done[s]),
        .issue      (issue[s]),
        .take_prev  (take_prev[s]),
        .take_next  (take_next[s]),
        .post_prev  (post_prev[s]),
        .post_next  (post_next[s])
      );
    end

    for (k = 0; k < NP; k++) begin : g_pair
      // stage k -> stage k+1
      dep_token_cnt #(.CW(CW)) u_fwd (
        .clk   (clk),
        .rst_n (rst_sync_n),
        .inc   (post_next[k]),
        .dec   (take_prev[k+1]),
        .count (fwd_cnt[k]),
        .ovf   (fwd_ovf[k])
      );
      // stage k+1 -> stage k
      dep_token_cnt #(.CW(CW)) u_bwd (
        .clk   (clk),
        .rst_n (rst_sync_n),
        .inc   (post_prev[k+1]),
        .dec   (take_next[k]),
        .count (bwd_cnt[k]),
        .ovf   (bwd_ovf[k])
      );
    end
  endgenerate

  assign err_d = err_q | (|fwd_ovf) | (|bwd_ovf);

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) err_q <= 1'b0;
    else             err_q <= err_d;
  end

  assign tok_err = err_q;
endmodule

// File: rtl/dep_token_ctrl_chk.sv
module dep_token_ctrl_chk #(
  parameter int NS = 4,
  parameter int CW = 4
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [NS-1:0]             req_valid,
  input logic [NS-1:0][3:0]        req_flags,
  input logic [NS-1:0]             issue,
  input logic [NS-1:0]             done,
  input logic                      tok_err,
  input logic [NS-2:0][CW-1:0]     fwd_cnt,
  input logic [NS-2:0][CW-1:0]     bwd_cnt
);
  localparam logic [CW-1:0] ONE  = CW'(1);
  localparam logic [CW-1:0] CMAX = '1;

  logic [NS-1:0] inflight;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) inflight <= '0;
    else        inflight <= (inflight & ~done) | issue;
  end

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    tok_err |=> tok_err); // R7

  genvar s, k;
  generate
    for (s = 0; s < NS; s++) begin : g_s
      AST_ISSUE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        issue[s] |-> req_valid[s]); // R5
      AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        issue[s] |-> !inflight[s]); // R5
      if (s > 0) begin : g_p
        AST_PREV_TOKEN: assert property (@(posedge clk) disable iff (!rst_n)
          (issue[s] && req_flags[s][3]) |-> (fwd_cnt[s-1] != '0)); // R2
      end
      if (s < NS - 1) begin : g_n
        AST_NEXT_TOKEN: assert property (@(posedge clk) disable iff (!rst_n)
          (issue[s] && req_flags[s][1]) |-> (bwd_cnt[s] != '0)); // R3
      end
    end
    for (k = 0; k < NS - 1; k++) begin : g_k
      AST_FWD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_cnt[k] != $past(fwd_cnt[k])) |->
        ((fwd_cnt[k] == $past(fwd_cnt[k]) + ONE) ||
         (fwd_cnt[k] == $past(fwd_cnt[k]) - ONE))); // R8
      AST_BWD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (bwd_cnt[k] != $past(bwd_cnt[k])) |->
        ((bwd_cnt[k] == $past(bwd_cnt[k]) + ONE) ||
         (bwd_cnt[k] == $past(bwd_cnt[k]) - ONE))); // R8
      AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(fwd_cnt[k]) == CMAX) |-> (fwd_cnt[k] != '0)); // R7
    end
  endgenerate
endmodule

bind dep_token_ctrl dep_token_ctrl_chk #(.NS(NS), .CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .req_valid (req_valid),
  .req_flags (req_flags),
  .issue     (issue),
  .done      (done),
  .tok_err   (tok_err),
  .fwd_cnt   (fwd_cnt),
  .bwd_cnt   (bwd_cnt)
);

// File: tb/tb_dep_token_ctrl.sv
module tb_dep_token_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 4;
  localparam int WATCHDOG = 20000;

  logic                clk;
  logic                rst_n;
  logic [NS-1:0]       req_valid;
  logic [NS-1:0][3:0]  req_flags;
  logic [NS-1:0]       issue;
  logic [NS-1:0]       done;
  logic                tok_err;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  // shadow token accounts for the schedule run
  int posted_f[NS-1], used_f[NS-1], posted_b[NS-1], used_b[NS-1];
  int issued_total;

  dep_token_ctrl #(.NS(NS), .CW(4)) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_flags (req_flags),
    .issue     (issue),
    .done      (done),
    .tok_err   (tok_err)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    req_valid = '0;
    req_flags = '0;
    done      = '0;
    rst_n     = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // Offer one instruction for one cycle and check the grant.
  task automatic attempt(int s, logic [3:0] f, bit exp, string req);
    @(negedge clk);
    req_valid[s] = 1'b1;
    req_flags[s] = f;
    #1;
    chk(issue[s] == exp, req, int'(issue[s]), int'(exp));
    @(posedge clk);
    #1 req_valid[s] = 1'b0;
  endtask

  task automatic complete(int s);
    @(negedge clk) done[s] = 1'b1;
    @(posedge clk);
    #1 done[s] = 1'b0;
  endtask

  task automatic t_reset_state();
    do_reset();
    #1;
    chk(issue == '0, "R9 no grant without request", int'(issue), 0);
    chk(tok_err == 1'b0, "R9 tok_err clear", int'(tok_err), 0);
    attempt(1, 4'b1000, 1'b0, "R9 counters start empty");
    for (int s = 0; s < NS; s++) begin
      attempt(s, 4'b0000, 1'b1, "R1 flags 0000 granted at once");
      complete(s);
    end
  endtask

  task automatic t_pop_prev();
    attempt(0, 4'b0001, 1'b1, "R1 loader give-next");
    attempt(1, 4'b1000, 1'b0, "R4 no token before producer done");
    complete(0);
    attempt(1, 4'b1000, 1'b1, "R2 take-prev after done");
    complete(1);
    attempt(1, 4'b1000, 1'b0, "R2 token consumed by grant");
  endtask

  task automatic t_busy();
    attempt(0, 4'b0000, 1'b1, "R5 first grant");
    attempt(0, 4'b0000, 1'b0, "R5 held while busy");
    complete(0);
    attempt(0, 4'b0000, 1'b1, "R5 grant after done");
    complete(0);
  endtask

  task automatic t_pop_next();
    attempt(2, 4'b0100, 1'b1, "R1 ALU give-prev");
    attempt(1, 4'b0010, 1'b0, "R3 held before ALU done");
    complete(2);
    attempt(1, 4'b0010, 1'b1, "R3 take-next granted");
    complete(1);
    attempt(1, 4'b0010, 1'b0, "R3 token consumed");
  endtask

  task automatic t_edges();
    attempt(0, 4'b1100, 1'b1, "R6 loader ignores prev flags");
    complete(0);
    attempt(3, 4'b0011, 1'b1, "R6 writer ignores next flags");
    complete(3);
    #1 chk(tok_err == 1'b0, "R6 no side effect", int'(tok_err), 0);
  endtask

  task automatic t_idle_done();
    attempt(0, 4'b0001, 1'b1, "R10 setup");
    complete(0);
    attempt(1, 4'b1000, 1'b1, "R10 consume");
    complete(1);
    complete(0);  // stray done on idle loader
    attempt(1, 4'b1000, 1'b0, "R10 idle done posts nothing");
  endtask

  task automatic t_same_cycle();
    attempt(0, 4'b0001, 1'b1, "R8 setup a");
    complete(0);
    attempt(0, 4'b0001, 1'b1, "R8 setup b");
    @(negedge clk);
    done[0]      = 1'b1;
    req_valid[1] = 1'b1;
    req_flags[1] = 4'b1000;
    #1 chk(issue[1] == 1'b1, "R8 take during post", int'(issue[1]), 1);
    @(posedge clk);
    #1;
    done[0]      = 1'b0;
    req_valid[1] = 1'b0;
    complete(1);
    attempt(1, 4'b1000, 1'b1, "R8 count kept at one");
    complete(1);
    attempt(1, 4'b1000, 1'b0, "R8 now empty");
  endtask

  task automatic t_saturate();
    for (int i = 0; i < 16; i++) begin
      attempt(0, 4'b0001, 1'b1, "R7 fill");
      complete(0);
      if (i == 14) begin
        @(negedge clk);
        chk(tok_err == 1'b0, "R7 no error at 15", int'(tok_err), 0);
      end
    end
    @(negedge clk);
    chk(tok_err == 1'b1, "R7 overflow flagged", int'(tok_err), 1);
    for (int i = 0; i < 15; i++) begin
      attempt(1, 4'b1000, 1'b1, "R7 drain saturated count");
      complete(1);
    end
    attempt(1, 4'b1000, 1'b0, "R7 held at 15 not 16");
    @(negedge clk);
    chk(tok_err == 1'b1, "R7 error sticky", int'(tok_err), 1);
  endtask

  function automatic int prog_len(int s);
    case (s)
      0: return 4;
      1: return 10;
      2: return 4;
      default: return 3;
    endcase
  endfunction

  function automatic logic [3:0] prog(int s, int i);
    logic [3:0] p0 [4]  = '{4'b0000, 4'b0001, 4'b0011, 4'b0011};
    logic [3:0] p1 [10] = '{4'b1000, 4'b0000, 4'b0000, 4'b0101, 4'b1000,
                            4'b0000, 4'b0101, 4'b1000, 4'b0001, 4'b0010};
    logic [3:0] p2 [4]  = '{4'b1001, 4'b1001, 4'b1001, 4'b0110};
    logic [3:0] p3 [3]  = '{4'b1000, 4'b1100, 4'b1000};
    case (s)
      0: return p0[i];
      1: return p1[i];
      2: return p2[i];
      default: return p3[i];
    endcase
  endfunction

  task automatic run_stage(int s);
    for (int i = 0; i < prog_len(s); i++) begin
      logic [3:0] f;
      bit got;
      f = prog(s, i);
      got = 1'b0;
      @(negedge clk);
      req_valid[s] = 1'b1;
      req_flags[s] = f;
      while (!got) begin
        #1;
        if (issue[s]) got = 1'b1;
        else @(negedge clk);
      end
      issued_total++;
      if (f[3] && s > 0) begin
        chk(used_f[s-1] < posted_f[s-1], "R11 take-prev after producer done",
            used_f[s-1], posted_f[s-1] - 1);
        used_f[s-1]++;
      end
      if (f[1] && s < NS - 1) begin
        chk(used_b[s] < posted_b[s], "R11 take-next after producer done",
            used_b[s], posted_b[s] - 1);
        used_b[s]++;
      end
      @(posedge clk);
      #1 req_valid[s] = 1'b0;
      repeat ($urandom_range(0, 5)) @(posedge clk);
      @(negedge clk) done[s] = 1'b1;
      @(posedge clk);
      #1 done[s] = 1'b0;
      if (f[0] && s < NS - 1) posted_f[s]++;
      if (f[2] && s > 0)      posted_b[s-1]++;
    end
  endtask

  task automatic t_schedule();
    do_reset();
    for (int k = 0; k < NS - 1; k++) begin
      posted_f[k] = 0; used_f[k] = 0; posted_b[k] = 0; used_b[k] = 0;
    end
    issued_total = 0;
    fork
      run_stage(0);
      run_stage(1);
      run_stage(2);
      run_stage(3);
    join
    chk(issued_total == 21, "R11 all instructions issued", issued_total, 21);
    @(negedge clk);
    chk(tok_err == 1'b0, "R11 no overflow in schedule", int'(tok_err), 0);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL R11 watchdog expired: actual=hung expected=complete");
      summary();
      $finish;
    end
  end

  initial begin
    t_reset_state();
    t_pop_prev();
    t_busy();
    t_pop_next();
    t_edges();
    t_idle_done();
    t_same_cycle();
    t_saturate();
    repeat (4) t_schedule();
    finished = 1'b1;
    summary();
    $finish;
  end
endmodule